// File: doc/BRIEF.md
# Configurable ADC Serial Output Port

This block is the serial readout side of an 18-bit sampling converter. A finished conversion word arrives on a parallel input with a one-cycle latch strobe. The port then sends the word out one bit at a time, most significant bit first, on a single data line. Static configuration inputs choose the output coding, the polarity of the frame signal, the polarity of the serial clock, and whether the port is clock master or slave.

As master, the port makes its own serial clock by dividing the system clock. A 2-bit setting picks one of four rates. A frame signal stays asserted across the whole word. In master mode the data input chooses when a frame runs. When it is high, a frame starts at the start of a conversion and carries the previous result. When it is low, a frame starts when the new result is latched.

As slave, the port follows an external serial clock. This clock is brought into the system clock domain through a two-flop synchronizer and an edge detector. Bits arriving on the data input are shifted in behind the word, so several converters can share one output line in a chain. A new result that arrives while a slave read is only partly done discards that read and raises a one-cycle error pulse. All outputs are gated by an active-low select and an active-low read.

Top module: `adc_serial_port`

## Requirements
- R1: In a master frame exactly 18 bits are sent. They go most significant bit first: bit k of the frame is word bit 17-k, and each bit is valid at a rising edge of the unflipped serial clock.
- R2: With `cfg_bin_i`=1 the word is sent unchanged (straight binary). With `cfg_bin_i`=0 word bit 17 is inverted before sending (two's complement).
- R3: The frame signal `sync_o` equals `cfg_sync_inv_i` when inactive and its inverse when active. It is active from before the first sampled bit until after the 18th, and inactive between frames and in slave mode.
- R4: `sclk_o` is the internal clock XOR `cfg_sclk_inv_i`. Between frames it rests at `cfg_sclk_inv_i`. In slave mode `cfg_sclk_inv_i` selects the shift edge of `sclk_i`: 0 = rising, 1 = falling. The data output then changes only after that edge.
- R5: The master bit period is 2*BASE_DIV*2^`cfg_div_i` system clocks (4, 8, 16, 32 with BASE_DIV=2).
- R6: In master mode with `sdin_i`=1, a frame starts on `conv_start_i` and carries the most recently latched word, and `latch_i` starts no frame. With `sdin_i`=0, a frame starts on `latch_i` and carries `word_i`, and `conv_start_i` starts no frame.
- R7: In slave mode the word's most significant bit is on `sdout_o` after `latch_i`. Each shift edge of `sclk_i` moves the next bit out within 6 system clocks.
- R8: In slave mode the level of `sdin_i` at each shift edge reappears on `sdout_o` 18 shift edges later.
- R9: In slave mode, a `latch_i` that arrives after 1 to 17 shift edges of the current word pulses `rd_err_o` high for exactly one cycle and loads the new word. A latch after 0 or 18 or more shift edges raises no error.
- R10: Unless `cs_ni` and `rd_ni` are both low, `sdout_en_o`=0, `sdout_o`=0, `sync_o` is inactive, `sclk_o` is at rest, and no master frame starts. Edges of `sclk_i` while `cs_ni` is high do not shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_i | input | 18 | Conversion result |
| latch_i | input | 1 | One-cycle strobe: result complete and valid |
| conv_start_i | input | 1 | One-cycle strobe: conversion started |
| cfg_bin_i | input | 1 | 1 = straight binary, 0 = two's complement |
| cfg_sync_inv_i | input | 1 | 1 = frame signal active low |
| cfg_sclk_inv_i | input | 1 | Serial clock polarity flip |
| cfg_ext_i | input | 1 | 1 = slave (external clock), 0 = master |
| cfg_div_i | input | 2 | Master clock divide select |
| cs_ni | input | 1 | Active-low select; also gates external clock |
| rd_ni | input | 1 | Active-low read |
| sclk_i | input | 1 | External serial clock |
| sdin_i | input | 1 | Chain data (slave) or read-mode select (master) |
| sclk_o | output | 1 | Internal serial clock |
| sync_o | output | 1 | Frame signal |
| sdout_o | output | 1 | Serial data |
| sdout_en_o | output | 1 | Output driver enable |
| rd_err_o | output | 1 | Incomplete slave read pulse |

## Verification
A master frame begins at the first clock edge after the trigger strobe. The bench samples on falling system-clock edges. It takes a bit at every rising edge of the unflipped `sclk_o` while the frame is active, and it measures the spacing between these edges against 2*BASE_DIV*2^div clocks. In slave mode the external clock passes through three flops before it can shift. So the bench waits 6 system clocks after each external edge before it reads `sdout_o`. It counts `rd_err_o` pulses on every falling clock edge and compares the count with its own model right after each latch. Random words cover all sixteen combinations of coding, frame polarity, clock polarity and read mode. Directed cases add partial-read errors and reads that are blocked by the select inputs.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;
  typedef struct packed {
    logic       bin;
    logic       sync_inv;
    logic       sclk_inv;
    logic       ext;
    logic [1:0] div;
  } port_cfg_t;
endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int BASE_DIV = 2,
  parameter int DIVW     = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [DIVW-1:0] div_i,
  output logic            sclk_o,
  output logic            fall_o
);
  localparam int MAXHALF = BASE_DIV << ((1 << DIVW) - 1);
  localparam int CNTW    = $clog2(MAXHALF + 1);

  logic [CNTW-1:0] cnt_q, half;
  logic            tc;

  assign half   = CNTW'(BASE_DIV) << div_i;
  assign tc     = (cnt_q == half - CNTW'(1));
  assign fall_o = run_i & tc & sclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (tc) begin
      cnt_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt_q <= cnt_q + CNTW'(1);
    end
  end
endmodule

// File: rtl/adc_edge_sync.sv
module adc_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], async_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
  assign fall_o = ~sh_q[1] & sh_q[2];
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_serial_pkg::*;
#(
  parameter int DW       = 18,
  parameter int BASE_DIV = 2,
  parameter int DIVW     = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DW-1:0]   word_i,
  input  logic            latch_i,
  input  logic            conv_start_i,
  input  logic            cfg_bin_i,
  input  logic            cfg_sync_inv_i,
  input  logic            cfg_sclk_inv_i,
  input  logic            cfg_ext_i,
  input  logic [DIVW-1:0] cfg_div_i,
  input  logic            cs_ni,
  input  logic            rd_ni,
  input  logic            sclk_i,
  input  logic            sdin_i,
  output logic            sclk_o,
  output logic            sync_o,
  output logic            sdout_o,
  output logic            sdout_en_o,
  output logic            rd_err_o
);
  localparam int CW = $clog2(DW + 1);

  port_cfg_t cfg;
  assign cfg = '{bin: cfg_bin_i, sync_inv: cfg_sync_inv_i, sclk_inv: cfg_sclk_inv_i,
                 ext: cfg_ext_i, div: cfg_div_i};

  logic          en, m_active_q, m_start, m_fall, m_sclk;
  logic          x_rise, x_fall, s_shift;
  logic [DW-1:0] word_q, fmt_new, fmt_old, sh_q;
  logic [CW-1:0] cnt_q;

  assign en      = ~cs_ni & ~rd_ni;
  assign fmt_new = {word_i[DW-1] ^ ~cfg.bin, word_i[DW-2:0]};
  assign fmt_old = {word_q[DW-1] ^ ~cfg.bin, word_q[DW-2:0]};

  // master read mode: sdin high = during conversion (previous word)
  assign m_start = ~cfg.ext & en & ~m_active_q & (sdin_i ? conv_start_i : latch_i);

  adc_sclk_div #(.BASE_DIV(BASE_DIV), .DIVW(DIVW)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (m_active_q),
    .div_i (cfg.div),
    .sclk_o(m_sclk),
    .fall_o(m_fall)
  );

  adc_edge_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sclk_i),
    .rise_o (x_rise),
    .fall_o (x_fall)
  );

  // chip select gates the external clock
  assign s_shift = cfg.ext & ~cs_ni & (cfg.sclk_inv ? x_fall : x_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else if (latch_i) word_q <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      m_active_q <= 1'b0;
      rd_err_o   <= 1'b0;
    end else begin
      rd_err_o <= 1'b0;
      if (cfg.ext) begin
        m_active_q <= 1'b0;
        if (latch_i) begin
          sh_q     <= fmt_new;
          cnt_q    <= '0;
          rd_err_o <= (cnt_q != '0) && (cnt_q != CW'(DW));
        end else if (s_shift) begin
          sh_q <= {sh_q[DW-2:0], sdin_i};
          if (cnt_q != CW'(DW)) cnt_q <= cnt_q + CW'(1);
        end
      end else if (m_start) begin
        sh_q       <= sdin_i ? fmt_old : fmt_new;
        cnt_q      <= '0;
        m_active_q <= 1'b1;
      end else if (m_active_q && m_fall) begin
        sh_q  <= {sh_q[DW-2:0], 1'b0};
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(DW - 1)) m_active_q <= 1'b0;
      end
    end
  end

  assign sdout_en_o = en;
  assign sdout_o    = en & sh_q[DW-1];
  assign sync_o     = (m_active_q & en & ~cfg.ext) ^ cfg.sync_inv;
  assign sclk_o     = (m_sclk & en & ~cfg.ext) ^ cfg.sclk_inv;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_sync_inv_i,
  input logic cfg_sclk_inv_i,
  input logic cfg_ext_i,
  input logic cs_ni,
  input logic rd_ni,
  input logic sclk_o,
  input logic sync_o,
  input logic sdout_o,
  input logic rd_err_o
);
  logic act;
  assign act = sync_o ^ cfg_sync_inv_i;

  AST_SYNC_IDLE_SLAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ext_i |-> !act); // R3
  AST_SCLK_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |-> (sclk_o == cfg_sclk_inv_i)); // R4
  AST_DATA_STABLE_AT_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_ext_i && act && $past(act) && $stable(cfg_sclk_inv_i)
     && $rose(sclk_o ^ cfg_sclk_inv_i)) |-> $stable(sdout_o)); // R1
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |=> !rd_err_o); // R9
  AST_ERR_SLAVE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> cfg_ext_i); // R9
  AST_GATED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> (!sdout_o && !act)); // R10
endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_sync_inv_i(cfg_sync_inv_i),
  .cfg_sclk_inv_i(cfg_sclk_inv_i),
  .cfg_ext_i     (cfg_ext_i),
  .cs_ni         (cs_ni),
  .rd_ni         (rd_ni),
  .sclk_o        (sclk_o),
  .sync_o        (sync_o),
  .sdout_o       (sdout_o),
  .rd_err_o      (rd_err_o)
);

// File: tb/adc_serial_port_test.sv
`timescale 1ns/1ps
module adc_serial_port_test;
  localparam int DW = 18;
  localparam int BASE_DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] word = '0;
  logic latch = 0, conv_start = 0, bin = 1, sync_inv = 0, sclk_inv = 0, ext = 0;
  logic [1:0] div = 0;
  logic cs_n = 0, rd_n = 0, sclk_in = 0, sdin = 0;
  logic sclk_o, sync_o, sdout_o, sdout_en_o, rd_err_o;

  int checks = 0, failures = 0, err_seen = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_serial_port #(.DW(DW), .BASE_DIV(BASE_DIV), .DIVW(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .latch_i(latch), .conv_start_i(conv_start),
    .cfg_bin_i(bin), .cfg_sync_inv_i(sync_inv), .cfg_sclk_inv_i(sclk_inv), .cfg_ext_i(ext),
    .cfg_div_i(div), .cs_ni(cs_n), .rd_ni(rd_n), .sclk_i(sclk_in), .sdin_i(sdin),
    .sclk_o(sclk_o), .sync_o(sync_o), .sdout_o(sdout_o), .sdout_en_o(sdout_en_o),
    .rd_err_o(rd_err_o));

  always @(negedge clk) begin
    cyc++;
    if (rd_err_o) err_seen++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [DW-1:0] coded(logic [DW-1:0] w, logic b);
    return b ? w : (w ^ (1 << (DW - 1)));
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  // master frame; during=1 uses read-during-convert
  task automatic master_frame(logic [DW-1:0] w, bit during);
    logic [DW-1:0] got = '0;
    int n = 0, gap = 0, last = -1, bad_gap = 0, bad_rest = 0, stray = 0;
    bit seen = 0, pr = 0;
    ext = 0; sdin = during;
    @(negedge clk);
    word = w;
    if (during) begin
      pulse(latch); // latch must not start a frame
      word = ~w;    // frame must carry the stored word
    end else begin
      pulse(conv_start);
    end
    repeat (40) begin
      @(negedge clk);
      if (sync_o != sync_inv) stray++;
    end
    check(stray == 0, "R6 wrong trigger starts no frame", stray, 0);
    if (during) pulse(conv_start); else pulse(latch);
    for (int i = 0; i < 2000; i++) begin
      bit s, r;
      s = (sync_o != sync_inv);
      r = sclk_o ^ sclk_inv;
      if (!s && sclk_o != sclk_inv) bad_rest++;
      if (s) seen = 1;
      if (s && r && !pr) begin
        got = {got[DW-2:0], sdout_o};
        if (last >= 0 && (i - last) != 2 * (BASE_DIV << div)) bad_gap++;
        last = i; n++;
      end
      if (seen && !s) break;
      pr = r;
      @(negedge clk);
    end
    check(n == DW, "R1/R3 bits inside frame", n, DW);
    check(got == coded(w, bin), "R1/R2/R6 frame data", got, coded(w, bin));
    check(bad_gap == 0, "R5 bit period", bad_gap, 0);
    check(bad_rest == 0, "R4 clock rest level", bad_rest, 0);
  endtask

  // slave read of w followed by 18 chain bits
  task automatic slave_read(logic [DW-1:0] w, logic [DW-1:0] chain);
    logic [DW-1:0] got = '0, got2 = '0;
    int e0;
    ext = 1;
    sclk_in = ~sclk_inv;
    repeat (6) @(negedge clk);
    word = w; e0 = err_seen;
    pulse(latch);
    repeat (2) @(negedge clk);
    check(sdout_o == coded(w, bin)[DW-1], "R7 msb after latch", sdout_o, coded(w, bin)[DW-1]);
    for (int k = 0; k < 2 * DW; k++) begin
      sclk_in = sclk_inv;  // sample edge
      repeat (6) @(negedge clk);
      if (k < DW) got = {got[DW-2:0], sdout_o};
      else        got2 = {got2[DW-2:0], sdout_o};
      sdin = (k < DW) ? chain[DW-1-k] : 1'b0;
      sclk_in = ~sclk_inv; // shift edge
      repeat (6) @(negedge clk);
    end
    check(got == coded(w, bin), "R4/R7 slave data", got, coded(w, bin));
    check(got2 == chain, "R8 chain pass-through", got2, chain);
    check(err_seen == e0, "R9 no error on full read", err_seen - e0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(sync_o == 0 && sclk_o == 0 && rd_err_o == 0, "R3/R4 reset state",
          {sync_o, sclk_o, rd_err_o}, 0);
    check(sdout_en_o == 1 && sdout_o == 0, "R10 reset enable", {sdout_en_o, sdout_o}, 2);

    // directed corners: all-zero and all-one words
    master_frame('0, 0);
    master_frame('1, 0);

    // master, every polarity/coding/mode combination, random words
    void'($urandom(32'h5eed));
    for (int c = 0; c < 16; c++) begin
      bin = c[0]; sync_inv = c[1]; sclk_inv = c[2]; div = 2'(c);
      master_frame(DW'($urandom), c[3]);
    end

    // slave, every polarity and coding combination
    for (int c = 0; c < 4; c++) begin
      bin = c[0]; sclk_inv = c[1]; sync_inv = ~c[0];
      slave_read(DW'($urandom), DW'($urandom));
      check(sync_o == sync_inv, "R3 frame idle in slave", sync_o, sync_inv);
    end

    // R9: partial read then new latch
    begin
      int e0;
      bin = 1; sclk_inv = 0; ext = 1;
      sclk_in = 1; repeat (6) @(negedge clk);
      word = 18'h2aaaa; pulse(latch);
      for (int k = 0; k < 5; k++) begin
        sclk_in = 0; repeat (6) @(negedge clk);
        sclk_in = 1; repeat (6) @(negedge clk);
      end
      e0 = err_seen;
      word = 18'h15555; pulse(latch);
      repeat (2) @(negedge clk);
      check(err_seen == e0 + 1, "R9 error pulse on partial read", err_seen - e0, 1);
      check(sdout_o == 1'b0, "R9 new word loaded", sdout_o, 0);
      e0 = err_seen;
      pulse(latch); // zero shifts since load
      repeat (2) @(negedge clk);
      check(err_seen == e0, "R9 no error with zero shifts", err_seen - e0, 0);
    end

    // R10: cs high blocks output and clock edges
    begin
      bin = 1; sclk_inv = 0; ext = 1;
      sclk_in = 1; repeat (6) @(negedge clk);
      word = 18'h20000; pulse(latch);
      cs_n = 1;
      repeat (2) @(negedge clk);
      check(sdout_o == 0 && sdout_en_o == 0, "R10 outputs off", {sdout_en_o, sdout_o}, 0);
      for (int k = 0; k < 4; k++) begin
        sclk_in = 0; repeat (6) @(negedge clk);
        sclk_in = 1; repeat (6) @(negedge clk);
      end
      cs_n = 0;
      repeat (2) @(negedge clk);
      check(sdout_o == 1, "R10 gated edges ignored", sdout_o, 1);
    end

    // R10: read high blocks a master frame
    begin
      int stray = 0;
      ext = 0; sdin = 0; sync_inv = 0; sclk_inv = 1; rd_n = 1;
      @(negedge clk);
      word = 18'h3ffff; pulse(latch);
      repeat (100) begin
        @(negedge clk);
        if (sync_o != 0 || sclk_o != 1 || sdout_o != 0) stray++;
      end
      check(stray == 0, "R10 no frame while read high", stray, 0);
      rd_n = 0;
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule